// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block turns one host request at a time into the command stream a single-data-rate SDRAM needs. The memory has four banks, 8192 rows of 512 columns and a 16-bit word. The controller drives chip select, RAS, CAS, WE, the bank-select pair, the shared row/column address bus, the clock enable and the two byte masks. After reset it brings the memory up on its own. It then serves read and write requests, and it opens or closes rows as each request needs. Refresh is slotted in at a fixed interval, and the controller can park the memory in power-down on demand. Every spacing rule is counted in clock cycles. The counts are taken from nanosecond parameters and the clock period, rounded up when the design is built.

The request port uses valid/ready. The host raises `req_valid` and holds bank, row, column, direction and the auto-precharge flag steady until it sees `req_ready` high at a rising edge. `req_ready` rises only in the cycle in which the column command for that request is decided. Any ACTIVE or PRECHARGE the request needs goes out first, while `req_ready` stays low. That is the only back-pressure. Refresh, power-down and timing waits all show up as a longer wait for `req_ready`. All memory pins are registered, so a command decided in cycle c appears on the pins in cycle c+1.

Top module: `sdram_seq`

## Requirements
- R1: After reset, CKE is high and only NOP is driven for at least `PWRUP_CYC` cycles. The controller then issues a precharge of all banks, then two AUTO REFRESH commands at least tRC apart, then one mode-register load. `req_ready` stays low until that load has been issued.
- R2: The mode-register load drives bank select 0. Its address is: bits 2:0 give the burst-length code (1→0, 2→1, 4→2, 8→3); bit 3 is 0, which selects sequential order; bits 6:4 give the CAS latency; bit 9 gives the write mode; all other bits are 0. With burst 4, latency 3 and write mode 0 the value is 0x032.
- R3: The pins {cs_n, ras_n, cas_n, we_n} carry NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, AUTO REFRESH=0001 and MODE LOAD=0000. ACTIVE puts the row on A12:A0. READ and WRITE put the column on A8:A0 and the auto-precharge flag on A10, with the other bits 0. A single-bank PRECHARGE drives an all-zero address, and precharge-all drives A10 high.
- R4: A request to a bank with no open row gets an ACTIVE for that bank and row. Its READ or WRITE follows no sooner than tRCD after the ACTIVE.
- R5: A request that hits the open row of its bank is served with a column command alone, with no ACTIVE. Row hits presented back to back are accepted, and their column commands issued, on consecutive cycles.
- R6: A request that misses the open row gets a PRECHARGE of that bank, then an ACTIVE. PRECHARGE comes no sooner than tRAS after that bank's ACTIVE. ACTIVE comes no sooner than tRP after PRECHARGE, tRC after the same bank's previous ACTIVE, and tRRD after any ACTIVE.
- R7: After a WRITE, a PRECHARGE of that bank comes no sooner than burst length + tWR − 1 cycles later. After a READ the gap is at least the burst length.
- R8: A READ or WRITE with the auto-precharge flag leaves its bank closed, so the next request to that bank starts with an ACTIVE. After a READ that ACTIVE comes no sooner than burst + tRP cycles later. After a WRITE it comes no sooner than burst + tWR − 1 + tRP cycles later.
- R9: Every `REF_INT_CYC` cycles after start-up a refresh becomes pending. If any bank is open, the controller first issues precharge-all, then AUTO REFRESH, and it accepts no request in between. No command follows the refresh sooner than tRC.
- R10: While `pd_req` is high and no refresh is pending, CKE goes low and no request is accepted. On exit, CKE rises together with a NOP, and the next command comes no sooner than ceil((tCKS + tCK)/tCK) cycles after the rising cycle.
- R11: Every cycle with no command carries NOP. DQM is driven high (both bits) until the mode-register load and low from then on.
- R12: `req_ready` is high only in a cycle whose decided command is the request's READ or WRITE, and that command appears on the pins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken at this rising edge |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 9 | Start column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Close the bank after this burst |
| pd_req | input | 1 | Ask for power-down |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 13 | Shared row/column address |
| sd_dqm | output | 2 | Byte masks |

## Verification
Each command reaches the pins one cycle after it is decided, so a request accepted at edge c has its column command visible in cycle c+1. The ACTIVE or PRECHARGE that goes before it comes out earlier, each separated by the spacing counts in R4 to R8. The bench samples the pins at the falling edge and stamps every command with the cycle count of the rising edge that produced it. It compares each request command, in order, against the queue its driver filled. It measures every spacing from those stamps against the minima above, and never checks an exact arrival cycle. The exceptions are back-to-back row hits, which must land exactly one cycle apart, and the power-down exit, whose NOP must share the cycle in which CKE rises.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  // nanoseconds to whole clocks, rounded up, never below one
  function automatic int ns_to_clk(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int burst_code(input int bl);
    case (bl)
      1:       return 0;
      2:       return 1;
      4:       return 2;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
  parameter int CW    = 6,
  parameter int ROW_W = 13,
  parameter int TRCD  = 1,
  parameter int TRAS  = 3,
  parameter int TRC   = 3,
  parameter int TRP   = 1,
  parameter int TWR   = 2,
  parameter int BL    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             pre,
  input  logic             rd,
  input  logic             wr,
  input  logic             ap,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             act_ok,
  output logic             col_ok,
  output logic             pre_ok
);

  // each load is (spacing - 1): counter reaches zero when the spacing is met
  localparam logic [CW-1:0] L_RCD   = CW'(TRCD - 1);
  localparam logic [CW-1:0] L_RAS   = CW'(TRAS - 1);
  localparam logic [CW-1:0] L_RC    = CW'(TRC - 1);
  localparam logic [CW-1:0] L_RP    = CW'(TRP - 1);
  localparam logic [CW-1:0] L_RDPRE = CW'(BL - 1);
  localparam logic [CW-1:0] L_WRPRE = CW'(BL + TWR - 2);
  localparam logic [CW-1:0] L_RDAP  = CW'(BL + TRP - 1);
  localparam logic [CW-1:0] L_WRAP  = CW'(BL + TWR + TRP - 2);

  logic [CW-1:0] cnt_act, cnt_col, cnt_pre;
  logic [CW-1:0] act_n, col_n, pre_n;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [CW-1:0] mx(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_comb begin
    act_n = dec(cnt_act);
    col_n = dec(cnt_col);
    pre_n = dec(cnt_pre);
    if (act) begin
      col_n = L_RCD;
      pre_n = mx(pre_n, L_RAS);
      act_n = mx(act_n, L_RC);
    end
    if (pre) act_n = mx(act_n, L_RP);
    if (rd) begin
      pre_n = mx(pre_n, L_RDPRE);
      if (ap) act_n = mx(act_n, L_RDAP);
    end
    if (wr) begin
      pre_n = mx(pre_n, L_WRPRE);
      if (ap) act_n = mx(act_n, L_WRAP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_act  <= '0;
      cnt_col  <= '0;
      cnt_pre  <= '0;
      is_open  <= 1'b0;
      open_row <= '0;
    end else begin
      cnt_act <= act_n;
      cnt_col <= col_n;
      cnt_pre <= pre_n;
      if (act) begin
        is_open  <= 1'b1;
        open_row <= row_in;
      end else if (pre || ((rd || wr) && ap)) begin
        is_open <= 1'b0;
      end
    end
  end

  assign act_ok = (cnt_act == '0);
  assign col_ok = (cnt_col == '0);
  assign pre_ok = (cnt_pre == '0);

  // R4: column command only to an open row once tRCD has elapsed
  p_col_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd || wr) |-> (is_open && cnt_col == '0));

  // R6: activation only of a closed bank whose wait has expired
  p_act_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (!is_open && cnt_act == '0));

  // R7: precharge never cuts into tRAS or write recovery
  p_pre_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pre |-> (cnt_pre == '0));

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int INTERVAL = 390
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic pend
);

  localparam int RW = $clog2(INTERVAL + 1);
  localparam logic [RW-1:0] RELOAD = RW'(INTERVAL - 1);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= RELOAD;
      pend <= 1'b0;
    end else begin
      if (!run) begin
        cnt <= RELOAD;
      end else if (cnt == '0) begin
        cnt <= RELOAD;
      end else begin
        cnt <= cnt - 1'b1;
      end
      if (run && cnt == '0) pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  // R9: a pending refresh is held until it is serviced
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int CLK_NS      = 20,
  parameter int TRCD_NS     = 18,
  parameter int TRP_NS      = 18,
  parameter int TRAS_NS     = 42,
  parameter int TRC_NS      = 60,
  parameter int TRRD_NS     = 12,
  parameter int TCKS_NS     = 2,
  parameter int TWR_CK      = 2,
  parameter int TMRD_CK     = 2,
  parameter int PWRUP_CYC   = 10000,
  parameter int REF_INT_CYC = 390,
  parameter int BURST_LEN   = 4,
  parameter int CAS_LAT     = 3,
  parameter int WR_SINGLE   = 0,
  parameter int BANKS       = 4,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int ADDR_W      = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [$clog2(BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  input  logic              req_ap,
  input  logic              pd_req,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [$clog2(BANKS)-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [1:0]        sd_dqm
);

  localparam int BA_W     = $clog2(BANKS);
  localparam int TRCD     = ns_to_clk(TRCD_NS, CLK_NS);
  localparam int TRP      = ns_to_clk(TRP_NS, CLK_NS);
  localparam int TRAS     = ns_to_clk(TRAS_NS, CLK_NS);
  localparam int TRC      = ns_to_clk(TRC_NS, CLK_NS);
  localparam int TRRD     = ns_to_clk(TRRD_NS, CLK_NS);
  localparam int EXIT_CYC = ns_to_clk(TCKS_NS + CLK_NS, CLK_NS);
  localparam int CW       = $clog2(BURST_LEN + TWR_CK + TRP + TRC + TMRD_CK + EXIT_CYC + 1) + 1;
  localparam int PW       = $clog2(PWRUP_CYC + 1);
  localparam int AP_BIT   = 10;
  localparam logic [CW-1:0] L_RP   = CW'(TRP - 1);
  localparam logic [CW-1:0] L_RC   = CW'(TRC - 1);
  localparam logic [CW-1:0] L_RRD  = CW'(TRRD - 1);
  localparam logic [CW-1:0] L_MRD  = CW'(TMRD_CK - 1);
  localparam logic [CW-1:0] L_EXIT = CW'(EXIT_CYC - 1);
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'(((WR_SINGLE & 1) << 9) | ((CAS_LAT & 7) << 4) | burst_code(BURST_LEN));

  typedef enum logic [2:0] {
    ST_PWR, ST_IPRE, ST_IREF1, ST_IREF2, ST_IMRS, ST_RUN, ST_PD
  } state_e;

  state_e st, st_n;
  sd_cmd_e cmd_q, cmd_n;
  logic [BA_W-1:0]   ba_n;
  logic [ADDR_W-1:0] addr_n;
  logic              cke_n;
  logic [1:0]        dqm_n;
  logic [PW-1:0]     pwr_cnt;
  logic [CW-1:0]     gap, rrd;
  logic              gap_ld;
  logic [CW-1:0]     gap_v;
  logic              act_v, pre_one, pre_all, rd_v, wr_v, ref_clr, ref_pend;

  logic [BANKS-1:0]  open_vec, act_ok_v, col_ok_v, pre_ok_v;
  logic [ROW_W-1:0]  open_row [BANKS];
  logic              any_open, all_pre_ok, all_act_ok, hit;

  // ---------------- per-bank timing state ----------------
  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic sel;
    assign sel = (req_bank == BA_W'(g));
    sdram_bank_timer #(
      .CW(CW), .ROW_W(ROW_W), .TRCD(TRCD), .TRAS(TRAS), .TRC(TRC),
      .TRP(TRP), .TWR(TWR_CK), .BL(BURST_LEN)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act_v && sel),
      .pre      (pre_all || (pre_one && sel)),
      .rd       (rd_v && sel),
      .wr       (wr_v && sel),
      .ap       (req_ap),
      .row_in   (req_row),
      .is_open  (open_vec[g]),
      .open_row (open_row[g]),
      .act_ok   (act_ok_v[g]),
      .col_ok   (col_ok_v[g]),
      .pre_ok   (pre_ok_v[g])
    );
  end

  sdram_refresh_timer #(.INTERVAL(REF_INT_CYC)) u_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st == ST_RUN || st == ST_PD),
    .clr   (ref_clr),
    .pend  (ref_pend)
  );

  assign any_open   = |open_vec;
  assign all_pre_ok = &pre_ok_v;
  assign all_act_ok = &act_ok_v;
  assign hit        = open_vec[req_bank] && (open_row[req_bank] == req_row);

  // ---------------- command decision ----------------
  always_comb begin
    st_n      = st;
    cmd_n     = CMD_NOP;
    ba_n      = '0;
    addr_n    = '0;
    cke_n     = 1'b1;
    dqm_n     = sd_dqm;
    gap_ld    = 1'b0;
    gap_v     = '0;
    act_v     = 1'b0;
    pre_one   = 1'b0;
    pre_all   = 1'b0;
    rd_v      = 1'b0;
    wr_v      = 1'b0;
    ref_clr   = 1'b0;
    req_ready = 1'b0;
    unique case (st)
      ST_PWR: if (pwr_cnt == '0) st_n = ST_IPRE;
      ST_IPRE: if (gap == '0 && all_pre_ok) begin
        cmd_n = CMD_PRE; addr_n[AP_BIT] = 1'b1; pre_all = 1'b1;
        gap_ld = 1'b1; gap_v = L_RP; st_n = ST_IREF1;
      end
      ST_IREF1: if (gap == '0 && all_act_ok) begin
        cmd_n = CMD_REF; gap_ld = 1'b1; gap_v = L_RC; st_n = ST_IREF2;
      end
      ST_IREF2: if (gap == '0 && all_act_ok) begin
        cmd_n = CMD_REF; gap_ld = 1'b1; gap_v = L_RC; st_n = ST_IMRS;
      end
      ST_IMRS: if (gap == '0) begin
        cmd_n = CMD_MRS; addr_n = MODE_WORD; dqm_n = 2'b00;
        gap_ld = 1'b1; gap_v = L_MRD; st_n = ST_RUN;
      end
      ST_RUN: begin
        if (ref_pend) begin
          if (gap == '0) begin
            if (any_open) begin
              if (all_pre_ok) begin
                cmd_n = CMD_PRE; addr_n[AP_BIT] = 1'b1; pre_all = 1'b1;
                gap_ld = 1'b1; gap_v = L_RP;
              end
            end else if (all_act_ok) begin
              cmd_n = CMD_REF; ref_clr = 1'b1; gap_ld = 1'b1; gap_v = L_RC;
            end
          end
        end else if (pd_req) begin
          if (gap == '0) begin
            cke_n = 1'b0; st_n = ST_PD;
          end
        end else if (req_valid && gap == '0) begin
          if (hit) begin
            if (col_ok_v[req_bank]) begin
              cmd_n = req_write ? CMD_WR : CMD_RD;
              ba_n = req_bank;
              addr_n[COL_W-1:0] = req_col;
              addr_n[AP_BIT] = req_ap;
              rd_v = !req_write;
              wr_v = req_write;
              req_ready = 1'b1;
            end
          end else if (open_vec[req_bank]) begin
            if (pre_ok_v[req_bank]) begin
              cmd_n = CMD_PRE; ba_n = req_bank; pre_one = 1'b1;
            end
          end else if (act_ok_v[req_bank] && rrd == '0) begin
            cmd_n = CMD_ACT; ba_n = req_bank;
            addr_n[ROW_W-1:0] = req_row; act_v = 1'b1;
          end
        end
      end
      ST_PD: begin
        cke_n = 1'b0;
        if (!pd_req || ref_pend) begin
          cke_n = 1'b1; gap_ld = 1'b1; gap_v = L_EXIT; st_n = ST_RUN;
        end
      end
      default: st_n = ST_PWR;
    endcase
  end

  // ---------------- state and registered pins ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_PWR;
      pwr_cnt <= PW'(PWRUP_CYC - 1);
      gap     <= '0;
      rrd     <= '0;
      cmd_q   <= CMD_NOP;
      sd_ba   <= '0;
      sd_addr <= '0;
      sd_cke  <= 1'b1;
      sd_dqm  <= 2'b11;
    end else begin
      st <= st_n;
      if (st == ST_PWR && pwr_cnt != '0) pwr_cnt <= pwr_cnt - 1'b1;
      if (gap_ld) gap <= gap_v;
      else if (gap != '0) gap <= gap - 1'b1;
      if (act_v) rrd <= L_RRD;
      else if (rrd != '0) rrd <= rrd - 1'b1;
      cmd_q   <= cmd_n;
      sd_ba   <= ba_n;
      sd_addr <= addr_n;
      sd_cke  <= cke_n;
      sd_dqm  <= dqm_n;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  // R12: an accepted request shows up as its column command one cycle later
  p_ready_col_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (cmd_q == CMD_RD || cmd_q == CMD_WR));

  // R10: clock enable rises only together with a NOP
  p_exit_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_cke) |-> (cmd_q == CMD_NOP));

  // R9: auto refresh reaches the pins only with every bank closed
  p_ref_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> (open_vec == '0));

  // R10: nothing is accepted while power-down is requested
  p_pd_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |-> !req_ready);

endmodule

// File: tb/sdram_seq_test.sv
module sdram_seq_test;

  localparam int CLK_NS = 20;
  localparam int PWRUP  = 10;
  localparam int REFINT = 1200;
  localparam int BL     = 4;
  localparam int TRCD   = 1;   // ceil(18/20)
  localparam int TRP    = 1;   // ceil(18/20)
  localparam int TRAS   = 3;   // ceil(42/20)
  localparam int TRC    = 3;   // ceil(60/20)
  localparam int TRRD   = 1;   // ceil(12/20)
  localparam int TWR    = 2;
  localparam int EXITC  = 2;   // ceil((2+20)/20)
  localparam logic [12:0] MODE_EXP = 13'h032;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0, pd_req = 1'b0;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic [8:0] req_col = '0;
  logic req_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba, sd_dqm;
  logic [12:0] sd_addr;

  sdram_seq #(.CLK_NS(CLK_NS), .PWRUP_CYC(PWRUP), .REF_INT_CYC(REFINT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_write(req_write), .req_ap(req_ap), .pd_req(pd_req),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // ---------------- scoreboard state ----------------
  logic [18:0] exp_q[$];
  int col_cyc[$];
  bit mdl_open[4];
  int mdl_row[4];
  bit obs_open[4];
  int last_act[4], last_pre[4], pre_min[4];
  int last_act_any = -100, last_ref = -100, rise_cyc = -100;
  int sys_idx = 0, ref_cnt = 0, first_cmd = -1;
  bit mrs_seen = 1'b0, cke_prev = 1'b1;

  initial for (int i = 0; i < 4; i++) begin
    last_act[i] = -100; last_pre[i] = -100; pre_min[i] = -100;
    obs_open[i] = 1'b0; mdl_open[i] = 1'b0; mdl_row[i] = 0;
  end

  // ---------------- monitor ----------------
  always @(negedge clk) if (rst_n && !done) begin
    logic [3:0] c;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (sd_cke && !cke_prev) begin
      chk(c == C_NOP, "R10 exit cycle carries NOP", int'(c), int'(C_NOP));
      rise_cyc = cyc;
    end
    cke_prev = sd_cke;
    if (sd_cke && c != C_NOP) begin
      if (first_cmd < 0) first_cmd = cyc;
      chk(cyc - rise_cyc >= EXITC, "R10 command after power-down exit", cyc - rise_cyc, EXITC);
      if (c == C_MRS) begin
        chk(sys_idx == 3, "R1 mode load position", sys_idx, 3);
        chk(sd_addr == MODE_EXP && sd_ba == 2'b00, "R2 mode word", int'(sd_addr), int'(MODE_EXP));
        chk(sd_dqm == 2'b00, "R11 dqm low from mode load", int'(sd_dqm), 0);
        mrs_seen = 1'b1; sys_idx++;
      end else if (c == C_REF) begin
        if (sys_idx < 4) begin
          chk(sys_idx == 1 || sys_idx == 2, "R1 refresh position", sys_idx, 1);
          sys_idx++;
        end
        chk(!(obs_open[0] | obs_open[1] | obs_open[2] | obs_open[3]), "R9 banks closed at refresh", 1, 0);
        chk(cyc - last_ref >= TRC, "R9 refresh spacing", cyc - last_ref, TRC);
        last_ref = cyc; ref_cnt++;
      end else if (c == C_PRE && sd_addr[10]) begin
        if (sys_idx == 0) begin
          chk(cyc >= PWRUP, "R1 power-up wait", cyc, PWRUP);
          sys_idx = 1;
        end
        for (int b = 0; b < 4; b++) begin
          if (obs_open[b]) begin
            chk(cyc >= pre_min[b], "R7 precharge-all recovery", cyc, pre_min[b]);
            chk(cyc - last_act[b] >= TRAS, "R6 precharge-all tRAS", cyc - last_act[b], TRAS);
          end
          obs_open[b] = 1'b0; last_pre[b] = cyc;
        end
      end else begin
        logic [18:0] e;
        int b;
        b = int'(sd_ba);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected command", int'(c), int'(C_NOP));
        end else begin
          e = exp_q.pop_front();
          chk({c, sd_ba, sd_addr} == e, "R3 command/bank/address", int'({c, sd_ba, sd_addr}), int'(e));
        end
        if (c == C_ACT) begin
          chk(!obs_open[b], "R6 activate of closed bank", int'(obs_open[b]), 0);
          chk(cyc - last_pre[b] >= TRP, "R8 activate after precharge", cyc - last_pre[b], TRP);
          chk(cyc - last_act[b] >= TRC, "R6 same-bank activate spacing", cyc - last_act[b], TRC);
          chk(cyc - last_act_any >= TRRD, "R6 cross-bank activate spacing", cyc - last_act_any, TRRD);
          chk(cyc - last_ref >= TRC, "R9 activate after refresh", cyc - last_ref, TRC);
          obs_open[b] = 1'b1; last_act[b] = cyc; last_act_any = cyc;
        end else if (c == C_PRE) begin
          chk(obs_open[b], "R6 precharge of open bank", int'(obs_open[b]), 1);
          chk(cyc - last_act[b] >= TRAS, "R6 precharge tRAS", cyc - last_act[b], TRAS);
          chk(cyc >= pre_min[b], "R7 write/read recovery", cyc, pre_min[b]);
          obs_open[b] = 1'b0; last_pre[b] = cyc;
        end else if (c == C_RD || c == C_WR) begin
          int pm;
          chk(obs_open[b], "R4 column to open bank", int'(obs_open[b]), 1);
          chk(cyc - last_act[b] >= TRCD, "R4 activate to column", cyc - last_act[b], TRCD);
          col_cyc.push_back(cyc);
          pm = (c == C_RD) ? cyc + BL : cyc + BL - 1 + TWR;
          if (pm > pre_min[b]) pre_min[b] = pm;
          if (sd_addr[10]) begin
            obs_open[b] = 1'b0; last_pre[b] = pm;
          end
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic send(input int b, input int row, input int col, input bit wr, input bit ap);
    logic [12:0] ca;
    if (!(mdl_open[b] && mdl_row[b] == row)) begin
      if (mdl_open[b]) exp_q.push_back({C_PRE, 2'(b), 13'd0});
      exp_q.push_back({C_ACT, 2'(b), 13'(row)});
    end
    ca = 13'(col) | (ap ? 13'h400 : 13'h000);
    exp_q.push_back({wr ? C_WR : C_RD, 2'(b), ca});
    mdl_open[b] = !ap; mdl_row[b] = row;
    req_bank = 2'(b); req_row = 13'(row); req_col = 9'(col);
    req_write = wr; req_ap = ap; req_valid = 1'b1;
    forever begin
      #2;
      if (req_ready) begin
        chk(mrs_seen, "R12 ready only after init", int'(mrs_seen), 1);
        @(posedge clk);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    int n, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sd_cke == 1'b1, "R1 cke high after reset", int'(sd_cke), 1);
    chk(sd_dqm == 2'b11, "R11 dqm high during init", int'(sd_dqm), 3);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R11 NOP during power-up", 0, int'(C_NOP));

    // first request presented during init: must wait for the mode load (R12)
    send(0, 5, 3, 1'b0, 1'b0);          // closed bank: ACT + READ (R4)
    send(0, 5, 4, 1'b1, 1'b0);          // row hit, back to back (R5)
    send(0, 5, 8, 1'b0, 1'b0);          // row hit (R5)
    repeat (3) @(negedge clk);
    n = col_cyc.size();
    chk(n == 3, "R5 three column commands", n, 3);
    if (n == 3) begin
      chk(col_cyc[1] - col_cyc[0] == 1, "R5 hit one cycle later", col_cyc[1] - col_cyc[0], 1);
      chk(col_cyc[2] - col_cyc[1] == 1, "R5 second hit one cycle later", col_cyc[2] - col_cyc[1], 1);
    end
    chk(first_cmd >= PWRUP, "R1 first command after power-up", first_cmd, PWRUP);

    send(1, 7, 511, 1'b1, 1'b0);        // write to bank 1
    send(1, 9, 2, 1'b0, 1'b0);          // row miss after write (R6, R7)
    send(2, 100, 6, 1'b0, 1'b1);        // read with auto-precharge (R8)
    send(2, 100, 7, 1'b1, 1'b0);        // same row, but bank closed (R8)
    send(3, 13'h1ABC, 1, 1'b1, 1'b1);   // write with auto-precharge (R8)
    send(3, 13'h1ABC, 2, 1'b0, 1'b0);   // reopen after write recovery (R8)
    send(0, 6, 0, 1'b0, 1'b0);          // row miss bank 0 (R6)
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected commands seen", exp_q.size(), 0);

    // periodic refresh with open banks (R9)
    w = 0;
    while (ref_cnt < 3 && w < 3000) begin @(negedge clk); w++; end
    chk(ref_cnt == 3, "R9 periodic refresh issued", ref_cnt, 3);
    for (int i = 0; i < 4; i++) mdl_open[i] = 1'b0;
    send(1, 9, 5, 1'b0, 1'b0);          // bank 1 was closed by refresh: needs ACT (R9)

    // power-down entry, stall and exit (R10)
    pd_req = 1'b1;
    req_bank = 2'd2; req_row = 13'd50; req_col = 9'd1; req_write = 1'b0; req_ap = 1'b0;
    req_valid = 1'b1;
    w = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #2;
      if (req_ready) w++;
    end
    chk(w == 0, "R10 no accept during power-down", w, 0);
    chk(sd_cke == 1'b0, "R10 cke low in power-down", int'(sd_cke), 0);
    pd_req = 1'b0;
    send(2, 50, 1, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    chk(sd_cke == 1'b1, "R10 cke high after exit", int'(sd_cke), 1);
    chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);
    chk(sd_dqm == 2'b00, "R11 dqm low in operation", int'(sd_dqm), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule